// File: doc/BRIEF.md
# Programmable SPI Flash Command Engine

The engine runs one complete serial-flash transaction each time software sets a start bit. A transaction has up to five phases, always in this order: an opcode byte, address bytes, dummy bytes, outgoing data bytes and incoming data bytes. Each phase has its own byte count and its own lane width of one, two or four wires. Software fills a small register file with the opcode, the address, the outgoing bytes and a configuration word, picks one of four devices and starts the engine. The start bit reads back as one until the last phase ends. Incoming bytes land in a read buffer that software collects afterwards.

The serial side is SPI mode 0. Each bit slot, or beat, lasts two system clocks: the serial clock is low for one clock and high for the next. Outputs change while the clock is low, and inputs are sampled at the end of the high half. A hold bit lets software keep one device selected across several back-to-back transactions, for example to stream a long page program in pieces. The register port is a plain single-cycle write strobe with a combinational read mux. No data stream passes the block edge, so there is no valid/ready handshake and no back-pressure to define.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the control word reads 0x0001_0000, every chip select is high, the serial clock is low, all output enables are low and the interrupt is low.
- R2: Writing the control word with bit 0 set starts a transaction. Bit 0 reads 1 until the transaction finishes and then reads 0. A start written while a transaction is running is ignored. When the engine is idle the serial clock and all output enables stay low.
- R3: Phases run in the order opcode, address, dummy, write data, read data. A phase with a count of zero produces no beats. The opcode phase runs only when configuration bit 10 is 1, and it sends bits 7:0 of the opcode register.
- R4: The address byte count is configuration bits 13:11, and values above 4 act as 4. The address is sent most significant byte first, using only the lowest N bytes of the address register.
- R5: The dummy byte count is configuration bits 23:21 (0 to 7). Dummy beats drive no output enable.
- R6: The write byte count is configuration bits 20:16, and values above 16 act as 16. Byte i comes from write word i/4, bits 8*(i%4)+7 down to 8*(i%4), and bytes go out in increasing i.
- R7: The read byte count is configuration bits 28:24, and values above 16 act as 16. Byte i is stored at the same position in the read words. Read bytes beyond the count keep their previous value.
- R8: Lane codes sit in configuration bits 1:0 (opcode), 3:2 (address), 7:6 (dummy), 5:4 (write) and 9:8 (read). Code 1 means two lanes, code 2 means four lanes, and codes 0 and 3 mean one lane. Bits go out most significant first. One lane drives io[0] and samples io[1]. Two lanes use io[1:0] and four lanes use io[3:0], with the higher lane carrying the more significant bit. Output enables cover exactly the lanes in use during opcode, address and write beats.
- R9: Each beat holds the serial clock low for one system clock and high for the next, and the clock never stays high for two clocks in a row.
- R10: Control bits 9:8 pick the device. Only that device's chip select goes low, and it stays low for every beat of the transaction.
- R11: Control bit 16 at 0 keeps the picked chip select low while the engine is idle, across transactions. At 1 it releases the chip select whenever no transaction runs.
- R12: Control bit 24 is a ready flag that is set when a transaction ends and cleared by a new start. The interrupt output equals control bit 25 AND the ready flag.
- R13: Register word addresses are 0 configuration, 1 control, 2 opcode, 3 address, 4 to 7 write words and 8 to 11 read words. The configuration, opcode and address registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_out | output | 4 | Serial data lanes, output value |
| spi_io_oe | output | 4 | Serial data lanes, output enable |
| spi_io_in | input | 4 | Serial data lanes, input value |
| irq | output | 1 | Transaction-complete interrupt |

## Verification
The sequencer reads the configuration, opcode, address and write words live during a transaction. The assertions and the expected beats therefore assume that software leaves those registers alone while bit 0 reads 1. The stimulus writes them only between transactions, and while busy it touches nothing but the control word, which it rewrites with unchanged device and hold fields. The device field is assumed to stay below NUM_CS. The bench's flash model changes the input lanes only during the high half of a beat, so their value is stable at the sampling edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_WR    = 3'd4,
    PH_RD    = 3'd5
  } phase_e;

  localparam int unsigned A_CFG  = 0;
  localparam int unsigned A_CTRL = 1;
  localparam int unsigned A_CMD  = 2;
  localparam int unsigned A_ADDR = 3;
  localparam int unsigned A_WD0  = 4;

  // lane code to lane count: 1 -> 2, 2 -> 4, others -> 1
  function automatic logic [2:0] lanes_of(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int REG_AW    = 4,
  localparam int BUF_WORDS = BUF_BYTES / 4,
  localparam int IW        = $clog2(BUF_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [REG_AW-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  logic                   done_i,
  input  logic                   rd_we_i,
  input  logic [IW-1:0]          rd_idx_i,
  input  logic [7:0]             rd_byte_i,
  output logic [31:0]            cfg_o,
  output logic [7:0]             cmd_o,
  output logic [31:0]            addr_o,
  output logic [BUF_BYTES*8-1:0] wbuf_o,
  output logic                   start_o,
  output logic                   busy_o,
  output logic [1:0]             dev_o,
  output logic                   cs_rel_o,
  output logic                   irq_o
);

  localparam int unsigned A_RD0 = A_WD0 + BUF_WORDS;

  logic [31:0] wd [BUF_WORDS];
  logic [31:0] rw [BUF_WORDS];
  logic        rdy, ie;

  assign start_o = we && (addr == REG_AW'(A_CTRL)) && wdata[0] && !busy_o;
  assign irq_o   = ie & rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o    <= '0;
      cmd_o    <= '0;
      addr_o   <= '0;
      dev_o    <= '0;
      cs_rel_o <= 1'b1;
      ie       <= 1'b0;
      rdy      <= 1'b0;
      busy_o   <= 1'b0;
      for (int w = 0; w < BUF_WORDS; w++) begin
        wd[w] <= '0;
        rw[w] <= '0;
      end
    end else begin
      if (we) begin
        if (addr == REG_AW'(A_CFG))  cfg_o  <= wdata;
        if (addr == REG_AW'(A_CMD))  cmd_o  <= wdata[7:0];
        if (addr == REG_AW'(A_ADDR)) addr_o <= wdata;
        if (addr == REG_AW'(A_CTRL)) begin
          dev_o    <= wdata[9:8];
          cs_rel_o <= wdata[16];
          ie       <= wdata[25];
        end
        for (int w = 0; w < BUF_WORDS; w++)
          if (addr == REG_AW'(A_WD0 + w)) wd[w] <= wdata;
      end
      if (start_o) begin
        busy_o <= 1'b1;
        rdy    <= 1'b0;
      end else if (done_i) begin
        busy_o <= 1'b0;
        rdy    <= 1'b1;
      end
      if (rd_we_i)
        rw[rd_idx_i[IW-1:2]][{rd_idx_i[1:0], 3'b000} +: 8] <= rd_byte_i;
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_wbuf
    assign wbuf_o[g*32 +: 32] = wd[g];
  end

  always_comb begin
    rdata = '0;
    if (addr == REG_AW'(A_CFG))  rdata = cfg_o;
    if (addr == REG_AW'(A_CMD))  rdata = {24'd0, cmd_o};
    if (addr == REG_AW'(A_ADDR)) rdata = addr_o;
    if (addr == REG_AW'(A_CTRL)) begin
      rdata[0]   = busy_o;
      rdata[9:8] = dev_o;
      rdata[16]  = cs_rel_o;
      rdata[24]  = rdy;
      rdata[25]  = ie;
    end
    for (int w = 0; w < BUF_WORDS; w++) begin
      if (addr == REG_AW'(A_WD0 + w)) rdata = wd[w];
      if (addr == REG_AW'(A_RD0 + w)) rdata = rw[w];
    end
  end

  // R2: the sequencer's completion pulse ends the busy state
  p_done_clears_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !busy_o);
  // R12: completion raises the ready flag
  p_done_sets_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> rdy);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  localparam int IW = $clog2(BUF_BYTES),
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [31:0]            cfg_i,
  input  logic [7:0]             cmd_i,
  input  logic [31:0]            addr_i,
  input  logic [BUF_BYTES*8-1:0] wbuf_i,
  input  logic [3:0]             io_in,
  output logic                   sclk_o,
  output logic [3:0]             io_out,
  output logic [3:0]             io_oe,
  output logic                   done_o,
  output logic                   rd_we_o,
  output logic [IW-1:0]          rd_idx_o,
  output logic [7:0]             rd_byte_o
);

  phase_e        phase, nxt_idle, nxt_cur;
  logic [CW-1:0] cnt [8];
  logic [1:0]    lc  [8];
  logic [CW-1:0] idx, ab;
  logic [3:0]    bcnt, bnext;
  logic          half, byte_end;
  logic [7:0]    rxb, rx_new, cur_byte, shifted;
  logic [2:0]    lanes;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg_i[31:29], cfg_i[15:14]};

  always_comb begin
    for (int p = 0; p < 8; p++) begin
      cnt[p] = '0;
      lc[p]  = 2'd0;
    end
    cnt[PH_CMD]   = CW'(cfg_i[10]);
    cnt[PH_ADDR]  = (cfg_i[13:11] > 3'd4) ? CW'(4) : CW'(cfg_i[13:11]);
    cnt[PH_DUMMY] = CW'(cfg_i[23:21]);
    cnt[PH_WR]    = (CW'(cfg_i[20:16]) > CW'(BUF_BYTES)) ? CW'(BUF_BYTES) : CW'(cfg_i[20:16]);
    cnt[PH_RD]    = (CW'(cfg_i[28:24]) > CW'(BUF_BYTES)) ? CW'(BUF_BYTES) : CW'(cfg_i[28:24]);
    lc[PH_CMD]    = cfg_i[1:0];
    lc[PH_ADDR]   = cfg_i[3:2];
    lc[PH_WR]     = cfg_i[5:4];
    lc[PH_DUMMY]  = cfg_i[7:6];
    lc[PH_RD]     = cfg_i[9:8];
  end

  // next non-empty phase; scanning downward leaves the lowest match
  always_comb begin
    nxt_idle = PH_IDLE;
    nxt_cur  = PH_IDLE;
    for (int p = 5; p >= 1; p--) begin
      if (cnt[p] != '0) begin
        nxt_idle = phase_e'(3'(p));
        if (3'(p) > phase) nxt_cur = phase_e'(3'(p));
      end
    end
  end

  assign ab    = cnt[PH_ADDR] - CW'(1) - idx;
  assign lanes = lanes_of(lc[phase]);

  always_comb begin
    case (phase)
      PH_CMD:  cur_byte = cmd_i;
      PH_ADDR: cur_byte = addr_i[{ab[1:0], 3'b000} +: 8];
      PH_WR:   cur_byte = wbuf_i[{idx[IW-1:0], 3'b000} +: 8];
      default: cur_byte = 8'h00;
    endcase
    shifted = cur_byte << bcnt;
    case (lanes)
      3'd2:    begin io_out = {2'b00, shifted[7:6]}; rx_new = {rxb[5:0], io_in[1:0]}; end
      3'd4:    begin io_out = shifted[7:4];          rx_new = {rxb[3:0], io_in};      end
      default: begin io_out = {3'b000, shifted[7]};  rx_new = {rxb[6:0], io_in[1]};  end
    endcase
    if (phase == PH_CMD || phase == PH_ADDR || phase == PH_WR)
      io_oe = (lanes == 3'd4) ? 4'b1111 : (lanes == 3'd2) ? 4'b0011 : 4'b0001;
    else
      io_oe = 4'b0000;
  end

  assign bnext    = bcnt + 4'(lanes);
  assign byte_end = (bnext == 4'd8);
  assign sclk_o   = half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      bcnt      <= '0;
      half      <= 1'b0;
      rxb       <= '0;
      done_o    <= 1'b0;
      rd_we_o   <= 1'b0;
      rd_idx_o  <= '0;
      rd_byte_o <= '0;
    end else begin
      done_o  <= 1'b0;
      rd_we_o <= 1'b0;
      if (phase == PH_IDLE) begin
        half <= 1'b0;
        if (start_i) begin
          phase <= nxt_idle;
          idx   <= '0;
          bcnt  <= '0;
          if (nxt_idle == PH_IDLE) done_o <= 1'b1;
        end
      end else if (!half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        rxb  <= rx_new;
        if (byte_end) begin
          bcnt <= '0;
          if (phase == PH_RD) begin
            rd_we_o   <= 1'b1;
            rd_idx_o  <= idx[IW-1:0];
            rd_byte_o <= rx_new;
          end
          if (idx + CW'(1) == cnt[phase]) begin
            idx   <= '0;
            phase <= nxt_cur;
            if (nxt_cur == PH_IDLE) done_o <= 1'b1;
          end else begin
            idx <= idx + CW'(1);
          end
        end else begin
          bcnt <= bnext;
        end
      end
    end
  end

  // R9: every high half of the serial clock lasts exactly one clock
  p_sclk_alternates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> !sclk_o);
  // R7: read bytes are only stored after a beat of the read phase
  p_store_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> $past(phase) == PH_RD);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int BUF_BYTES = 16,
  parameter int REG_AW    = 4,
  localparam int IW = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in,
  output logic              irq
);

  logic [31:0]            cfg, addr;
  logic [7:0]             cmd, rd_byte;
  logic [BUF_BYTES*8-1:0] wbuf;
  logic                   start, busy, done, rd_we, cs_rel;
  logic [1:0]             dev;
  logic [IW-1:0]          rd_idx;

  spi_cmd_regs #(.BUF_BYTES(BUF_BYTES), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done_i(done), .rd_we_i(rd_we), .rd_idx_i(rd_idx),
    .rd_byte_i(rd_byte), .cfg_o(cfg), .cmd_o(cmd), .addr_o(addr), .wbuf_o(wbuf),
    .start_o(start), .busy_o(busy), .dev_o(dev), .cs_rel_o(cs_rel), .irq_o(irq)
  );

  spi_cmd_seq #(.BUF_BYTES(BUF_BYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg), .cmd_i(cmd),
    .addr_i(addr), .wbuf_i(wbuf), .io_in(spi_io_in), .sclk_o(spi_sclk),
    .io_out(spi_io_out), .io_oe(spi_io_oe), .done_o(done), .rd_we_o(rd_we),
    .rd_idx_o(rd_idx), .rd_byte_o(rd_byte)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs_n[g] = !((busy || !cs_rel) && (dev == 2'(g)));
  end

  // R10: never more than one device selected
  p_one_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  // R10: a clock beat always happens under a chip select
  p_sclk_under_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> (spi_cs_n != '1));
  // R2: an idle engine keeps the bus quiet
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!spi_sclk && spi_io_oe == 4'b0000));

endmodule

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;

  typedef struct packed {
    logic [3:0] oe;
    logic [3:0] out;
    logic [3:0] inp;
    logic [3:0] csn;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, irq;
  logic [3:0]  spi_cs_n, spi_io_out, spi_io_oe;
  logic [3:0]  spi_io_in = 4'h0;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  beat_t exp_q[$];
  logic [7:0] wbytes [16];
  logic [7:0] rbytes [16];
  logic [7:0] rmodel [16];
  logic       cs_rel = 1'b1;

  always #5 clk = ~clk;

  spi_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .spi_io_in(spi_io_in), .irq(irq)
  );

  // monitor: one expected beat per high half of the serial clock
  always @(negedge clk) begin
    if (rst_n && spi_sclk) begin
      beat_t e;
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errors++;
        $display("FAIL R3 unexpected beat: oe=%h out=%h, expected no beat", spi_io_oe, spi_io_out);
      end else begin
        e = exp_q.pop_front();
        if (spi_io_oe !== e.oe || (spi_io_out & e.oe) !== (e.out & e.oe) || spi_cs_n !== e.csn) begin
          mon_errors++;
          $display("FAIL R8 beat: oe/out/cs=%h/%h/%h expected %h/%h/%h",
                   spi_io_oe, spi_io_out & e.oe, spi_cs_n, e.oe, e.out & e.oe, e.csn);
        end
        spi_io_in = e.inp;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    reg_addr = 4'(a);
    #1;
    d = reg_rdata;
  endtask

  // driver: expected beats of one byte
  task automatic push_byte(input int kind, input logic [1:0] code, input logic [7:0] b, input logic [3:0] csn);
    int ln;
    ln = (code == 2'd1) ? 2 : (code == 2'd2) ? 4 : 1;
    for (int s = 0; s < 8; s += ln) begin
      logic [7:0] sh;
      logic [3:0] bits;
      beat_t e;
      sh = b << s;
      bits = (ln == 1) ? {3'b0, sh[7]} : (ln == 2) ? {2'b0, sh[7:6]} : sh[7:4];
      e.csn = csn;
      e.oe = 4'h0; e.out = 4'h0; e.inp = 4'h0;
      if (kind == 0) begin
        e.oe = (ln == 1) ? 4'b0001 : (ln == 2) ? 4'b0011 : 4'b1111;
        e.out = bits;
      end else if (kind == 2) begin
        e.inp = (ln == 1) ? {2'b0, sh[7], 1'b0} : bits;
      end
      exp_q.push_back(e);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int ce, input int ac, input int dc, input int wc, input int rc,
                                         input int lcm, input int la, input int ld, input int lw, input int lr);
    return 32'((ce << 10) | (ac << 11) | (dc << 21) | (wc << 16) | (rc << 24) |
               lcm | (la << 2) | (ld << 6) | (lw << 4) | (lr << 8));
  endfunction

  task automatic do_xfer(input logic [31:0] cfg, input logic [7:0] cmd, input logic [31:0] adr,
                         input int dev, input logic ie, input logic dbl);
    logic [3:0]  csn;
    logic [31:0] v, ctrl, tmp;
    int acnt, wcnt, rcnt;
    csn  = ~(4'b1 << dev);
    acnt = (cfg[13:11] > 4) ? 4 : int'(cfg[13:11]);
    wcnt = (cfg[20:16] > 16) ? 16 : int'(cfg[20:16]);
    rcnt = (cfg[28:24] > 16) ? 16 : int'(cfg[28:24]);
    if (cfg[10]) push_byte(0, cfg[1:0], cmd, csn);
    for (int i = 0; i < acnt; i++) begin
      tmp = adr >> (8 * (acnt - 1 - i));
      push_byte(0, cfg[3:2], tmp[7:0], csn);
    end
    for (int i = 0; i < int'(cfg[23:21]); i++) push_byte(1, cfg[7:6], 8'h00, csn);
    for (int i = 0; i < wcnt; i++) push_byte(0, cfg[5:4], wbytes[i], csn);
    for (int i = 0; i < rcnt; i++) begin
      push_byte(2, cfg[9:8], rbytes[i], csn);
      rmodel[i] = rbytes[i];
    end
    wreg(0, cfg);
    wreg(2, {24'd0, cmd});
    wreg(3, adr);
    for (int w = 0; w < 4; w++)
      wreg(4 + w, {wbytes[4*w+3], wbytes[4*w+2], wbytes[4*w+1], wbytes[4*w]});
    rreg(0, v); check("R13 config readback", v, cfg);
    rreg(3, v); check("R13 address readback", v, adr);
    ctrl = 32'((int'(ie) << 25) | (int'(cs_rel) << 16) | (dev << 8) | 1);
    wreg(1, ctrl);
    rreg(1, v);
    check("R2 start bit reads 1 while running", {31'd0, v[0]}, 32'd1);
    check("R12 ready cleared by start", {31'd0, v[24]}, 32'd0);
    if (dbl) begin
      repeat (6) @(negedge clk);
      wreg(1, ctrl);
    end
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      rreg(1, v);
      if (!v[0]) break;
    end
    check("R2 start bit clears at end", {31'd0, v[0]}, 32'd0);
    check("R12 ready set at end", {31'd0, v[24]}, 32'd1);
    check("R12 interrupt", {31'd0, irq}, {31'd0, ie});
    check("R3 all expected beats seen", exp_q.size(), 0);
    check("R11 chip select after end", {28'd0, spi_cs_n}, {28'd0, cs_rel ? 4'hF : csn});
    for (int w = 0; w < 4; w++) begin
      rreg(8 + w, v);
      check("R7 read word", v, {rmodel[4*w+3], rmodel[4*w+2], rmodel[4*w+1], rmodel[4*w]});
    end
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      wbytes[i] = 8'(8'h3C + 29 * i);
      rbytes[i] = 8'(8'hA5 ^ (17 * i + 3));
      rmodel[i] = 8'h00;
    end
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rreg(1, v);
        check("R1 control after reset", v, 32'h0001_0000);
        check("R1 chip selects", {28'd0, spi_cs_n}, 32'hF);
        check("R1 sclk/oe/irq", {26'd0, spi_sclk, irq, spi_io_oe}, 32'd0);
        // R3 opcode only, single lane
        do_xfer(mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0), 8'h06, 32'h0, 0, 1'b0, 1'b0);
        // R4 three address bytes, upper byte ignored; R7 single-lane read
        do_xfer(mk_cfg(1, 3, 0, 0, 4, 0, 0, 0, 0, 0), 8'h03, 32'h55A1B2C3, 1, 1'b0, 1'b0);
        // R5 R8 quad address, quad dummy, 16-byte quad read; R12 interrupt on
        for (int i = 0; i < 16; i++) rbytes[i] = 8'(rbytes[i] + 8'h11);
        do_xfer(mk_cfg(1, 4, 2, 0, 16, 0, 2, 2, 0, 2), 8'hEB, 32'h12345678, 2, 1'b1, 1'b0);
        // R6 dual address and five dual write bytes
        do_xfer(mk_cfg(1, 3, 0, 5, 0, 0, 1, 0, 1, 0), 8'hA2, 32'h00ABCDEF, 3, 1'b0, 1'b0);
        // R6 write count 20 acts as 16, quad lanes, no opcode
        do_xfer(mk_cfg(0, 0, 0, 20, 0, 0, 0, 0, 2, 0), 8'h00, 32'h0, 0, 1'b0, 1'b0);
        // R4 count 6 acts as 4; R8 code 3 as one lane; R7 partial read keeps upper bytes
        for (int i = 0; i < 16; i++) rbytes[i] = 8'(rbytes[i] ^ 8'h5A);
        do_xfer(mk_cfg(1, 6, 1, 0, 3, 0, 3, 1, 0, 0), 8'h0B, 32'h89ABCDEF, 0, 1'b0, 1'b0);
        // R3 empty transaction finishes with no beats
        do_xfer(32'h0, 8'h00, 32'h0, 1, 1'b0, 1'b0);
        // R11 manual hold across two transactions
        cs_rel = 1'b0;
        wreg(1, 32'h0000_0100);
        check("R11 hold selects device when idle", {28'd0, spi_cs_n}, 32'hD);
        do_xfer(mk_cfg(1, 0, 0, 2, 0, 0, 0, 0, 0, 0), 8'h02, 32'h0, 1, 1'b0, 1'b0);
        do_xfer(mk_cfg(1, 0, 0, 3, 0, 0, 0, 0, 1, 0), 8'h32, 32'h0, 1, 1'b0, 1'b0);
        cs_rel = 1'b1;
        wreg(1, 32'h0001_0100);
        check("R11 release deselects", {28'd0, spi_cs_n}, 32'hF);
        // R2 second start while running is ignored
        do_xfer(mk_cfg(1, 3, 0, 4, 0, 0, 0, 0, 0, 0), 8'h02, 32'h00010203, 2, 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        check("R2 no extra beats after ignored start", exp_q.size(), 0);
        // R12 interrupt follows enable bit
        wreg(1, 32'h0001_0200);
        check("R12 interrupt off when disabled", {31'd0, irq}, 32'd0);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
    $finish;
  end

endmodule